// File: doc/BRIEF.md
# Capture/Compare Timer Array

This block pairs one 16-bit up-counter with a small set of compare/capture channels (two by default). The counter advances on a tick taken from one of four sources: the core clock divided by six, the core clock divided by two, an overflow pulse from a neighbouring timer, or falling edges on an external count pin. Each channel owns a 16-bit value register and one pin in each direction. By its mode bits a channel can latch the counter on pin edges, raise a flag when the counter steps onto its value, flip its output pin on that event, or drive an 8-bit pulse-width waveform whose duty is double-buffered.

Software reaches everything through a byte-wide register port: a write strobe with address and data, and an asynchronous read path. Flags are sticky. Hardware sets them and software clears them by writing the control register. A single interrupt line combines the counter wrap flag and the channel flags, each gated by its own enable.

Top module: `pca_top`

## Requirements
- R1: After reset every register reads 0x00, every channel output is 0 and the interrupt is low.
- R2: The source field (mode register at address 0, bits 2:1) picks the tick. A value of 0 gives one tick per six clocks, 1 gives one tick per two clocks, 2 gives one tick per clock in which `tmr_ovf` is high, and 3 gives one tick per falling edge of `eci` after a two-flop synchronizer. The counter (address 2 is the low byte, address 3 the high byte, both writable) steps by one per tick only while the run bit (control register at address 1, bit 0) is set.
- R3: While `idle` is high and the idle-stop bit (mode bit 3) is set, the counter holds. With idle-stop clear, `idle` has no effect.
- R4: A step from 0xFFFF to 0x0000 sets the wrap flag (control bit 1). The flag stays set until software writes 0 to it. When hardware sets it and software writes it in the same cycle, the set wins.
- R5: Channel m has its config at address 4+4m, its value low byte at 5+4m and its value high byte at 6+4m. Config bit 5 enables capture on a rising pin edge and bit 6 enables capture on a falling edge. With both bits set, either edge captures. On an enabled edge of the synchronized `cex_in[m]`, the counter is copied into the value register and the channel flag (control bit 2+m) is set. A disabled edge changes neither.
- R6: With config bits 1 (compare enable) and 2 (match enable) set, a counter step that lands on the channel value sets the channel flag. Writing a value equal to the current count does not set the flag until the counter later steps onto it.
- R7: With config bits 1, 2 and 3 (toggle) set and bit 4 clear, `cex_out[m]` inverts on each such match.
- R8: With config bits 1 and 4 (pulse-width) set, `cex_out[m]` is 0 while the counter low byte is below the value low byte and 1 otherwise.
- R9: In pulse-width mode, a step from low byte 0xFF to 0x00 copies the value high byte into the value low byte.
- R10: `irq` is high when the wrap flag and mode bit 0 are both set, or when any channel flag and that channel's config bit 0 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle | input | 1 | Core idle indication |
| tmr_ovf | input | 1 | Overflow pulse from a neighbouring timer |
| eci | input | 1 | External count pin, asynchronous |
| cex_in | input | NUM_MOD | Channel capture pins, asynchronous |
| cex_out | output | NUM_MOD | Channel output pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that software leaves a channel's mode unchanged in the cycle after a toggle match, and that it does not write the counter while it also expects a step to be seen. The bench keeps to this rule. It changes modes and counter values only while no tick source is active, and it produces ticks one at a time through the timer-overflow input. The bench uses free-running sources only in windows where it just counts the steps. Pin edges are held for several clocks, so the synchronizer always sees them.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int DATA_W       = 8;
  localparam int CNT_W        = 16;
  localparam int PRE_MAX      = 5;
  localparam int REG_MODE     = 0;
  localparam int REG_CTRL     = 1;
  localparam int REG_CNTL     = 2;
  localparam int REG_CNTH     = 3;
  localparam int REG_MOD_BASE = 4;
  localparam int MOD_STRIDE   = 4;
  localparam int CFG_W        = 7;

  typedef enum logic [1:0] {
    SRC_DIV6 = 2'd0,
    SRC_DIV2 = 2'd1,
    SRC_TMR  = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;

  typedef struct packed {
    logic cap_fall;
    logic cap_rise;
    logic pwm;
    logic toggle;
    logic match_en;
    logic cmp_en;
    logic irq_en;
  } mod_cfg_t;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic pwm_high(input logic [DATA_W-1:0] lo, input logic [DATA_W-1:0] duty);
    return lo >= duty;
  endfunction

  function automatic logic low_wraps(input logic [CNT_W-1:0] c);
    return c[DATA_W-1:0] == {DATA_W{1'b1}};
  endfunction

  function automatic int mod_addr(input int m, input int k);
    return REG_MOD_BASE + m * MOD_STRIDE + k;
  endfunction
endpackage

// File: rtl/pca_sync.sv
module pca_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic level,
  output logic prev
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d};
  end

  assign level = sh[STAGES-1];
  assign prev  = sh[STAGES];
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase import pca_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src,
  input  logic             run,
  input  logic             idle,
  input  logic             idle_stop,
  input  logic             tmr_ovf,
  input  logic             eci,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic             inc_ev,
  output logic             wrap_ev,
  output logic             lo_wrap_ev
);
  localparam int PRE_W = $clog2(PRE_MAX + 1);

  logic [PRE_W-1:0] pre;
  logic             eci_lvl, eci_prev, eci_fall;
  logic             tick;

  pca_sync #(.STAGES(SYNC_STAGES)) u_eci_sync (
    .clk(clk), .rst_n(rst_n), .d(eci), .level(eci_lvl), .prev(eci_prev)
  );
  assign eci_fall = eci_prev & ~eci_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n)                        pre <= '0;
    else if (pre == PRE_W'(PRE_MAX))   pre <= '0;
    else                               pre <= pre + PRE_W'(1);
  end

  always_comb begin
    case (src_e'(src))
      SRC_DIV6: tick = (pre == PRE_W'(PRE_MAX));
      SRC_DIV2: tick = pre[0];
      SRC_TMR:  tick = tmr_ovf;
      default:  tick = eci_fall;
    endcase
  end

  assign inc_ev     = tick & run & ~(idle & idle_stop) & ~(wr_lo | wr_hi);
  assign wrap_ev    = inc_ev & (&count);
  assign lo_wrap_ev = inc_ev & low_wraps(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      if (wr_lo) count[DATA_W-1:0]     <= wdata;
      if (wr_hi) count[CNT_W-1:DATA_W] <= wdata;
      if (inc_ev) count <= step_count(count);
    end
  end
endmodule

// File: rtl/pca_module.sv
module pca_module import pca_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              inc_ev,
  input  logic              lo_wrap_ev,
  input  logic              cex_in,
  input  logic              wr_cfg,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output mod_cfg_t          cfg,
  output logic [CNT_W-1:0]  cap,
  output logic              cap_ev,
  output logic              match_ev,
  output logic              tog_ev,
  output logic              pwm_sel,
  output logic              set_ev,
  output logic              cex_out
);
  logic pin_lvl, pin_prev, pin_rise, pin_fall;
  logic tog_q;

  pca_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(cex_in), .level(pin_lvl), .prev(pin_prev)
  );
  assign pin_rise = pin_lvl & ~pin_prev;
  assign pin_fall = pin_prev & ~pin_lvl;

  assign cap_ev   = (pin_rise & cfg.cap_rise) | (pin_fall & cfg.cap_fall);
  assign match_ev = inc_ev & cfg.cmp_en & cfg.match_en & (step_count(count) == cap);
  assign tog_ev   = match_ev & cfg.toggle;
  assign pwm_sel  = cfg.cmp_en & cfg.pwm;
  assign set_ev   = cap_ev | match_ev;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= '0;
    else if (wr_cfg) cfg <= mod_cfg_t'(wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap <= '0;
    end else if (cap_ev) begin
      cap <= count;
    end else begin
      if (pwm_sel && lo_wrap_ev) cap[DATA_W-1:0] <= cap[CNT_W-1:DATA_W];
      if (wr_lo) cap[DATA_W-1:0]     <= wdata;
      if (wr_hi) cap[CNT_W-1:DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_ev) tog_q <= ~tog_q;
  end

  assign cex_out = pwm_sel ? pwm_high(count[DATA_W-1:0], cap[DATA_W-1:0]) : tog_q;
endmodule

// File: rtl/pca_top.sv
module pca_top import pca_pkg::*; #(
  parameter int NUM_MOD     = 2,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle,
  input  logic               tmr_ovf,
  input  logic               eci,
  input  logic [NUM_MOD-1:0] cex_in,
  output logic [NUM_MOD-1:0] cex_out,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq
);
  localparam int MODE_W = 4;

  logic [MODE_W-1:0]  mode_q;
  logic               run, ovf_flag;
  logic [NUM_MOD-1:0] mod_flag;
  logic [CNT_W-1:0]   count;
  logic               inc_ev, wrap_ev, lo_wrap_ev;
  logic               wr_mode, wr_ctrl, wr_cntl, wr_cnth, cnt_wr;
  logic               idle_stop, ovf_ie;
  logic [NUM_MOD-1:0] cap_ev, match_ev, tog_ev, pwm_sel, set_ev, mod_ie;
  mod_cfg_t           cfg_rd [NUM_MOD];
  logic [CNT_W-1:0]   cap_rd [NUM_MOD];

  function automatic logic wr_hit(input int idx);
    return wr_en && (wr_addr == ADDR_W'(idx));
  endfunction

  assign wr_mode   = wr_hit(REG_MODE);
  assign wr_ctrl   = wr_hit(REG_CTRL);
  assign wr_cntl   = wr_hit(REG_CNTL);
  assign wr_cnth   = wr_hit(REG_CNTH);
  assign cnt_wr    = wr_cntl | wr_cnth;
  assign ovf_ie    = mode_q[0];
  assign idle_stop = mode_q[3];

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= wr_data[MODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      ovf_flag <= 1'b0;
      mod_flag <= '0;
    end else begin
      if (wr_ctrl) begin
        run      <= wr_data[0];
        ovf_flag <= wr_data[1];
        mod_flag <= wr_data[2 +: NUM_MOD];
      end
      if (wrap_ev) ovf_flag <= 1'b1;
      for (int m = 0; m < NUM_MOD; m++)
        if (set_ev[m]) mod_flag[m] <= 1'b1;
    end
  end

  pca_timebase #(.SYNC_STAGES(SYNC_STAGES)) u_tb (
    .clk(clk), .rst_n(rst_n), .src(mode_q[2:1]), .run(run), .idle(idle),
    .idle_stop(idle_stop), .tmr_ovf(tmr_ovf), .eci(eci), .wr_lo(wr_cntl),
    .wr_hi(wr_cnth), .wdata(wr_data), .count(count), .inc_ev(inc_ev),
    .wrap_ev(wrap_ev), .lo_wrap_ev(lo_wrap_ev)
  );

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_mod
    pca_module #(.SYNC_STAGES(SYNC_STAGES)) u_mod (
      .clk(clk), .rst_n(rst_n), .count(count), .inc_ev(inc_ev),
      .lo_wrap_ev(lo_wrap_ev), .cex_in(cex_in[g]),
      .wr_cfg(wr_hit(mod_addr(g, 0))), .wr_lo(wr_hit(mod_addr(g, 1))),
      .wr_hi(wr_hit(mod_addr(g, 2))), .wdata(wr_data),
      .cfg(cfg_rd[g]), .cap(cap_rd[g]), .cap_ev(cap_ev[g]),
      .match_ev(match_ev[g]), .tog_ev(tog_ev[g]), .pwm_sel(pwm_sel[g]),
      .set_ev(set_ev[g]), .cex_out(cex_out[g])
    );
    assign mod_ie[g] = cfg_rd[g].irq_en;
  end

  assign irq = (ovf_flag & ovf_ie) | (|(mod_flag & mod_ie));

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(REG_MODE)) rd_data = DATA_W'(mode_q);
    if (rd_addr == ADDR_W'(REG_CTRL)) rd_data = DATA_W'({mod_flag, ovf_flag, run});
    if (rd_addr == ADDR_W'(REG_CNTL)) rd_data = count[DATA_W-1:0];
    if (rd_addr == ADDR_W'(REG_CNTH)) rd_data = count[CNT_W-1:DATA_W];
    for (int m = 0; m < NUM_MOD; m++) begin
      if (rd_addr == ADDR_W'(mod_addr(m, 0))) rd_data = DATA_W'(cfg_rd[m]);
      if (rd_addr == ADDR_W'(mod_addr(m, 1))) rd_data = cap_rd[m][DATA_W-1:0];
      if (rd_addr == ADDR_W'(mod_addr(m, 2))) rd_data = cap_rd[m][CNT_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/pca_checker.sv
module pca_checker import pca_pkg::*; #(
  parameter int NUM_MOD = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   count,
  input logic               inc_ev,
  input logic               wrap_ev,
  input logic               cnt_wr,
  input logic               run,
  input logic               idle,
  input logic               idle_stop,
  input logic               ovf_flag,
  input logic [NUM_MOD-1:0] mod_flag,
  input logic [NUM_MOD-1:0] set_ev,
  input logic [NUM_MOD-1:0] match_ev,
  input logic [NUM_MOD-1:0] cap_ev,
  input logic [NUM_MOD-1:0] tog_ev,
  input logic [NUM_MOD-1:0] pwm_sel,
  input logic [NUM_MOD-1:0] cex_out,
  input logic               irq
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev |=> count == CNT_W'($past(count) + CNT_W'(1))); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count)); // R2
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && idle_stop && !cnt_wr) |=> $stable(count)); // R3
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (ovf_flag && count == '0)); // R4
  AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_ev) |=> ((mod_flag & $past(cap_ev)) == $past(cap_ev))); // R5
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_ev) |=> ((mod_flag & $past(match_ev)) == $past(match_ev))); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag || (|mod_flag))); // R10

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_chk
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_ev[g] && !pwm_sel[g]) |=> cex_out[g] != $past(cex_out[g])); // R7
  end

  logic unused_ok;
  assign unused_ok = ^set_ev;
endmodule

bind pca_top pca_checker #(.NUM_MOD(NUM_MOD)) u_pca_checker (
  .clk(clk), .rst_n(rst_n), .count(count), .inc_ev(inc_ev), .wrap_ev(wrap_ev),
  .cnt_wr(cnt_wr), .run(run), .idle(idle), .idle_stop(idle_stop),
  .ovf_flag(ovf_flag), .mod_flag(mod_flag), .set_ev(set_ev),
  .match_ev(match_ev), .cap_ev(cap_ev), .tog_ev(tog_ev), .pwm_sel(pwm_sel),
  .cex_out(cex_out), .irq(irq)
);

// File: tb/tb_pca_top.sv
module tb_pca_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_MOD    = 2;
  localparam int ADDR_W     = 4;
  localparam int WD_CYCLES  = 20000;

  // {counter low byte, duty, expected level}
  localparam logic [16:0] PWM_VEC [6] = '{
    {8'h00, 8'h00, 1'b1},
    {8'h7F, 8'h80, 1'b0},
    {8'h80, 8'h80, 1'b1},
    {8'hFF, 8'h80, 1'b1},
    {8'h10, 8'hFF, 1'b0},
    {8'hFF, 8'hFF, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle = 1'b0, tmr_ovf = 1'b0, eci = 1'b0;
  logic [NUM_MOD-1:0] cex_in = '0;
  logic [NUM_MOD-1:0] cex_out;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] va, vb;

  always #(CLK_PERIOD/2) clk = ~clk;

  pca_top #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .idle(idle), .tmr_ovf(tmr_ovf), .eci(eci),
    .cex_in(cex_in), .cex_out(cex_out), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    #1 v = rd_data;
  endtask

  task automatic tick_once();
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic set_cnt(input int v);
    wr(2, v & 8'hFF);
    wr(3, (v >> 8) & 8'hFF);
  endtask

  task automatic chk_rd(input string tag, input int a, input int exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, int'(v), exp);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 11; a++) chk_rd("R1 reg", a, 0);
    chk("R1 cex_out", int'(cex_out), 0);
    chk("R1 irq", int'(irq), 0);

    // R8 compare table, counter stopped
    wr(4, 8'h12);
    for (int i = 0; i < 6; i++) begin
      wr(2, PWM_VEC[i][16:9]);
      wr(5, PWM_VEC[i][8:1]);
      chk("R8 pwm level", int'(cex_out[0]), int'(PWM_VEC[i][0]));
    end

    // R9 duty reload at low-byte rollover
    wr(6, 8'h40);
    set_cnt(16'h00FF);
    wr(0, 8'h04);
    wr(1, 8'h01);
    tick_once();
    wr(1, 8'h00);
    chk_rd("R9 low byte reloaded", 5, 8'h40);
    chk_rd("R9 high byte kept", 6, 8'h40);
    chk_rd("R9 counter low", 2, 8'h00);
    chk_rd("R9 counter high", 3, 8'h01);
    chk("R9 pwm after reload", int'(cex_out[0]), 0);

    // R6 match on module 1
    wr(8, 8'h06);
    set_cnt(16'h1234);
    wr(9, 8'h34); wr(10, 8'h12);
    wr(1, 8'h01);
    chk_rd("R6 equal write no flag", 1, 8'h01);
    tick_once();
    chk_rd("R6 passed value no flag", 1, 8'h01);
    wr(2, 8'h33);
    tick_once();
    chk_rd("R6 match flag", 1, 8'h09);
    chk("R10 irq masked", int'(irq), 0);
    wr(8, 8'h07);
    @(negedge clk);
    chk("R10 module irq", int'(irq), 1);
    wr(1, 8'h01);
    @(negedge clk);
    chk("R10 irq cleared", int'(irq), 0);

    // R7 toggle on module 0
    wr(4, 8'h0E);
    wr(5, 8'h10); wr(6, 8'h00);
    set_cnt(16'h000E);
    tick_once();
    chk("R7 no toggle before match", int'(cex_out[0]), 0);
    tick_once();
    chk("R7 toggle high", int'(cex_out[0]), 1);
    chk_rd("R6 flag from toggle match", 1, 8'h05);
    wr(2, 8'h0F);
    tick_once();
    chk("R7 toggle low", int'(cex_out[0]), 0);

    // R4 wrap flag and R10 gating
    wr(1, 8'h01);
    set_cnt(16'hFFFF);
    tick_once();
    chk_rd("R4 wrap flag", 1, 8'h03);
    chk_rd("R4 counter zero", 3, 8'h00);
    chk("R10 wrap masked", int'(irq), 0);
    wr(0, 8'h05);
    @(negedge clk);
    chk("R10 wrap irq", int'(irq), 1);
    tick_once();
    chk_rd("R4 flag sticky", 1, 8'h03);
    wr(1, 8'h01);
    chk_rd("R4 flag cleared", 1, 8'h01);
    chk("R10 irq low after clear", int'(irq), 0);

    // R5 capture on module 0, counter stopped
    wr(1, 8'h00);
    wr(4, 8'h20);
    set_cnt(16'h5A3C);
    @(negedge clk); cex_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    chk_rd("R5 rise capture low", 5, 8'h3C);
    chk_rd("R5 rise capture high", 6, 8'h5A);
    chk_rd("R5 capture flag", 1, 8'h04);
    wr(1, 8'h00);
    set_cnt(16'h0102);
    @(negedge clk); cex_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    chk_rd("R5 fall ignored", 5, 8'h3C);
    chk_rd("R5 no flag on ignored edge", 1, 8'h00);
    wr(4, 8'h40);
    set_cnt(16'h0304);
    @(negedge clk); cex_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    chk_rd("R5 rise ignored in fall mode", 5, 8'h3C);
    @(negedge clk); cex_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    chk_rd("R5 fall capture", 5, 8'h04);
    wr(4, 8'h60);
    set_cnt(16'h0506);
    @(negedge clk); cex_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    chk_rd("R5 both-edge capture", 6, 8'h05);

    // R2 sources
    wr(4, 8'h00);
    set_cnt(0);
    wr(0, 8'h04);
    tick_once();
    chk_rd("R2 stopped holds", 2, 8'h00);
    wr(0, 8'h02);
    wr(1, 8'h01);
    rd(2, va);
    repeat (59) @(negedge clk);
    rd(2, vb);
    chk("R2 div2 steps", int'(8'(vb - va)), 30);
    wr(0, 8'h00);
    rd(2, va);
    repeat (59) @(negedge clk);
    rd(2, vb);
    chk("R2 div6 steps", int'(8'(vb - va)), 10);
    wr(1, 8'h00);
    set_cnt(0);
    wr(0, 8'h06);
    wr(1, 8'h01);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); eci = 1'b1;
      repeat (3) @(negedge clk); eci = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk_rd("R2 external edges", 2, 5);

    // R3 idle gating
    wr(0, 8'h0C);
    idle = 1'b1;
    tick_once();
    chk_rd("R3 idle freeze", 2, 5);
    wr(0, 8'h04);
    tick_once();
    chk_rd("R3 idle without stop counts", 2, 6);
    idle = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule